// File: doc/BRIEF.md
# Ratio-Weighted Two-Group DMA Arbiter

This block shares a DMA engine between two groups of FIFO requesters, a fast group that is normally favoured and a slow group that must not starve. Within each group a round-robin picker chooses one FIFO. Between the groups, a programmable ratio N lets the fast group take N packet grants in a row before the slow group is favoured for a single grant. Once the slow group has been served, the fast group is favoured again.

Two copies of this logic run side by side. One serves transmit and the other serves receive. Each copy has its own ratio, and both ratios come from one 32-bit configuration word. A grant is a one-hot bit per FIFO, registered, and it is held until the DMA engine pulses the packet-done strobe for that direction. On that same edge the next winner is chosen, so back-to-back packets leave no idle cycle.

Top module: `dma_ratio_arb`

## Requirements
- R1: With every FIFO of both groups requesting without pause and an effective ratio N, the grants repeat as N fast-group packets followed by 1 slow-group packet.
- R2: The fast group counts consecutive fast packets that have completed. Once that count has reached the effective ratio, the slow group wins the next contest in which both groups request, even if an idle gap comes before it.
- R3: Once a slow-group grant has been issued, the fast group wins the next contest in which both groups request.
- R4: A ratio field of 0 acts as a ratio of 1, so the two groups alternate one-for-one under contention.
- R5: If any FIFO requests while the direction is idle, or in the cycle its packet-done strobe is high, a grant is visible in the next cycle.
- R6: In each direction at most one grant bit is high across both groups, and a newly issued grant goes to a FIFO that was requesting in the cycle before.
- R7: A grant stays unchanged until the packet-done strobe of its direction is high. A done strobe while no grant is held has no effect.
- R8: Within a group, the search for the next grant starts at the FIFO index one above the last granted index in that group and wraps from the top index to 0.
- R9: The transmit ratio is taken from configuration bits 4:0 and the receive ratio from bits 12:8. All other bits are ignored. The two directions never affect each other.
- R10: When only one group requests, that group is granted whatever the consecutive-packet count is.
- R11: A ratio change takes effect at the next grant decision. If the count already exceeds the new ratio, the count is treated as having reached it.
- R12: While reset is asserted, and directly after it, every grant output is 0 and the consecutive count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Configuration word: transmit ratio in 4:0, receive ratio in 12:8 |
| tx_hi_req | input | NUM_HI | Transmit fast-group FIFO requests |
| tx_lo_req | input | NUM_LO | Transmit slow-group FIFO requests |
| tx_done | input | 1 | Transmit packet finished |
| rx_hi_req | input | NUM_HI | Receive fast-group FIFO requests |
| rx_lo_req | input | NUM_LO | Receive slow-group FIFO requests |
| rx_done | input | 1 | Receive packet finished |
| tx_hi_gnt | output | NUM_HI | Transmit fast-group one-hot grant |
| tx_lo_gnt | output | NUM_LO | Transmit slow-group one-hot grant |
| rx_hi_gnt | output | NUM_HI | Receive fast-group one-hot grant |
| rx_lo_gnt | output | NUM_LO | Receive slow-group one-hot grant |

## Verification
A wrong consecutive count shows up at the ports the first time both groups contend after the count goes wrong. The slow grant then arrives one or more packets early or late, so the error becomes visible within at most N+1 packets. A stale round-robin pointer shows as the wrong one-hot bit on the very next grant in that group that sees more than one request. A broken hold or missed re-arbitration changes the grant outputs in the cycle after the faulty done handling. Because every cycle is compared against a behavioural model, each of these faults is reported on the clock where it first reaches a grant output.

// File: rtl/dra_pkg.sv
package dra_pkg;
    localparam int RATIO_W  = 5;
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 8;

    typedef enum logic {
        GRP_HI = 1'b0,
        GRP_LO = 1'b1
    } grp_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(ptr) + k) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/ratio_arb.sv
module ratio_arb
    import dra_pkg::*;
#(
    parameter int NUM_HI = 4,
    parameter int NUM_LO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [NUM_HI-1:0]  hi_req,
    input  logic [NUM_LO-1:0]  lo_req,
    input  logic               done,
    output logic [NUM_HI-1:0]  hi_gnt,
    output logic [NUM_LO-1:0]  lo_gnt
);
    localparam int HW = (NUM_HI > 1) ? $clog2(NUM_HI) : 1;
    localparam int LW = (NUM_LO > 1) ? $clog2(NUM_LO) : 1;

    typedef struct packed {
        logic               busy;
        grp_e               grp;
        logic [HW-1:0]      hptr;
        logic [LW-1:0]      lptr;
        logic [NUM_HI-1:0]  hgnt;
        logic [NUM_LO-1:0]  lgnt;
        logic [RATIO_W-1:0] hcnt;
    } st_t;

    st_t s_d, s_q;

    logic          h_found, l_found;
    logic [HW-1:0] h_idx;
    logic [LW-1:0] l_idx;

    rr_pick #(.N(NUM_HI)) u_hi_pick (
        .req   (hi_req),
        .ptr   (s_q.hptr),
        .found (h_found),
        .idx   (h_idx)
    );

    rr_pick #(.N(NUM_LO)) u_lo_pick (
        .req   (lo_req),
        .ptr   (s_q.lptr),
        .found (l_found),
        .idx   (l_idx)
    );

    logic [RATIO_W-1:0] eff_d;
    logic [RATIO_W-1:0] hc_d;
    logic               decide_d;
    logic               take_hi_d;

    always_comb begin
        s_d      = s_q;
        eff_d    = (ratio == '0) ? RATIO_W'(1) : ratio;
        hc_d     = s_q.hcnt;
        if (s_q.busy && done && s_q.grp == GRP_HI) begin
            hc_d = (hc_d >= eff_d) ? eff_d : hc_d + 1'b1;
        end
        decide_d  = !s_q.busy || done;
        take_hi_d = h_found && (!l_found || hc_d < eff_d);
        s_d.hcnt  = hc_d;
        if (decide_d) begin
            s_d.busy = 1'b0;
            s_d.hgnt = '0;
            s_d.lgnt = '0;
            if (take_hi_d) begin
                s_d.busy = 1'b1;
                s_d.grp  = GRP_HI;
                s_d.hgnt = NUM_HI'(1) << h_idx;
                s_d.hptr = (int'(h_idx) == NUM_HI - 1) ? '0 : h_idx + 1'b1;
            end else if (l_found) begin
                s_d.busy = 1'b1;
                s_d.grp  = GRP_LO;
                s_d.lgnt = NUM_LO'(1) << l_idx;
                s_d.lptr = (int'(l_idx) == NUM_LO - 1) ? '0 : l_idx + 1'b1;
                s_d.hcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_gnt = s_q.hgnt;
    assign lo_gnt = s_q.lgnt;

    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_gnt, lo_gnt}));

    // R7
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{hi_gnt, lo_gnt} && !done) |=> ($stable(hi_gnt) && $stable(lo_gnt)));

    // R5
    no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|{hi_req, lo_req}) && (!(|{hi_gnt, lo_gnt}) || done)) |=> (|{hi_gnt, lo_gnt}));

    // R6
    gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!(|{hi_gnt, lo_gnt}) || done) && (|{hi_req, lo_req}))
        |=> ((({hi_gnt, lo_gnt} & $past({hi_req, lo_req})) != '0)));

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (s_q.hcnt == '0 && hi_gnt == '0 && lo_gnt == '0));
endmodule

// File: rtl/dma_ratio_arb.sv
module dma_ratio_arb
    import dra_pkg::*;
#(
    parameter int NUM_HI = 4,
    parameter int NUM_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic [NUM_HI-1:0] tx_hi_req,
    input  logic [NUM_LO-1:0] tx_lo_req,
    input  logic              tx_done,
    input  logic [NUM_HI-1:0] rx_hi_req,
    input  logic [NUM_LO-1:0] rx_lo_req,
    input  logic              rx_done,
    output logic [NUM_HI-1:0] tx_hi_gnt,
    output logic [NUM_LO-1:0] tx_lo_gnt,
    output logic [NUM_HI-1:0] rx_hi_gnt,
    output logic [NUM_LO-1:0] rx_lo_gnt
);
    logic [RATIO_W-1:0] tx_ratio;
    logic [RATIO_W-1:0] rx_ratio;

    assign tx_ratio = cfg_word[TX_LSB +: RATIO_W];
    assign rx_ratio = cfg_word[RX_LSB +: RATIO_W];

    ratio_arb #(.NUM_HI(NUM_HI), .NUM_LO(NUM_LO)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio  (tx_ratio),
        .hi_req (tx_hi_req),
        .lo_req (tx_lo_req),
        .done   (tx_done),
        .hi_gnt (tx_hi_gnt),
        .lo_gnt (tx_lo_gnt)
    );

    ratio_arb #(.NUM_HI(NUM_HI), .NUM_LO(NUM_LO)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio  (rx_ratio),
        .hi_req (rx_hi_req),
        .lo_req (rx_lo_req),
        .done   (rx_done),
        .hi_gnt (rx_hi_gnt),
        .lo_gnt (rx_lo_gnt)
    );
endmodule

// File: tb/sim_dma_ratio_arb.sv
module sim_dma_ratio_arb;
    localparam int NH = 4;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_word = '0;
    logic [NH-1:0] tx_hi_req = '0, rx_hi_req = '0;
    logic [NL-1:0] tx_lo_req = '0, rx_lo_req = '0;
    logic          tx_done = 1'b0, rx_done = 1'b0;
    logic [NH-1:0] tx_hi_gnt, rx_hi_gnt;
    logic [NL-1:0] tx_lo_gnt, rx_lo_gnt;

    always #5 clk = ~clk;

    dma_ratio_arb #(.NUM_HI(NH), .NUM_LO(NL)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .tx_hi_req (tx_hi_req),
        .tx_lo_req (tx_lo_req),
        .tx_done   (tx_done),
        .rx_hi_req (rx_hi_req),
        .rx_lo_req (rx_lo_req),
        .rx_done   (rx_done),
        .tx_hi_gnt (tx_hi_gnt),
        .tx_lo_gnt (tx_lo_gnt),
        .rx_hi_gnt (rx_hi_gnt),
        .rx_lo_gnt (rx_lo_gnt)
    );

    int    total = 0;
    int    bad = 0;
    string phase = "R12 reset";
    int    m_busy[2], m_grp[2], m_idx[2], m_hp[2], m_lp[2], m_hc[2];
    int    lo_seen = 0;

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_busy[c] = 0; m_grp[c] = 0; m_idx[c] = 0;
            m_hp[c] = 0; m_lp[c] = 0; m_hc[c] = 0;
        end
    endtask

    task automatic model_step(input int c, input logic [NH-1:0] hr,
                              input logic [NL-1:0] lr, input logic dn, input int ratio);
        int eff, hc, hi_i, lo_i;
        bit hf, lf;
        eff = (ratio == 0) ? 1 : ratio;
        hc  = m_hc[c];
        if (m_busy[c] != 0 && dn && m_grp[c] == 0) hc = (hc >= eff) ? eff : hc + 1;
        if (m_busy[c] == 0 || dn) begin
            hf = 0; lf = 0; hi_i = 0; lo_i = 0;
            for (int k = 0; k < NH; k++)
                if (!hf && hr[(m_hp[c] + k) % NH]) begin hf = 1; hi_i = (m_hp[c] + k) % NH; end
            for (int k = 0; k < NL; k++)
                if (!lf && lr[(m_lp[c] + k) % NL]) begin lf = 1; lo_i = (m_lp[c] + k) % NL; end
            m_busy[c] = 0;
            if (hf && (!lf || hc < eff)) begin
                m_busy[c] = 1; m_grp[c] = 0; m_idx[c] = hi_i; m_hp[c] = (hi_i + 1) % NH;
            end else if (lf) begin
                m_busy[c] = 1; m_grp[c] = 1; m_idx[c] = lo_i; m_lp[c] = (lo_i + 1) % NL;
                hc = 0;
            end
        end
        m_hc[c] = hc;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            model_step(0, tx_hi_req, tx_lo_req, tx_done, int'(cfg_word[4:0]));
            model_step(1, rx_hi_req, rx_lo_req, rx_done, int'(cfg_word[12:8]));
        end
    end

    task automatic check_dir(input int c, input logic [NH-1:0] ah, input logic [NL-1:0] al);
        logic [NH-1:0] eh;
        logic [NL-1:0] el;
        eh = (m_busy[c] != 0 && m_grp[c] == 0) ? NH'(1) << m_idx[c] : '0;
        el = (m_busy[c] != 0 && m_grp[c] == 1) ? NL'(1) << m_idx[c] : '0;
        total++;
        if (ah !== eh || al !== el) begin
            bad++;
            $display("FAIL %s dir=%0d hi=%b lo=%b expected hi=%b lo=%b",
                     phase, c, ah, al, eh, el);
        end
    endtask

    always @(negedge clk) begin
        check_dir(0, tx_hi_gnt, tx_lo_gnt);
        check_dir(1, rx_hi_gnt, rx_lo_gnt);
        if (rst_n && |tx_lo_gnt) lo_seen++;
    end

    function automatic logic [3:0] pick_req(input int rmode);
        case (rmode)
            0: return 4'hF;
            1: return 4'h0;
            4: return 4'($urandom);
            5: return 4'($urandom) & 4'($urandom);
            default: return 4'h0;
        endcase
    endfunction

    task automatic run(input string ph, input int cycles, input int rmode, input int dmode);
        phase = ph;
        repeat (cycles) begin
            @(negedge clk);
            #1;
            tx_hi_req = (rmode == 2 || rmode == 3) ? '0 : pick_req(rmode);
            rx_hi_req = (rmode == 2 || rmode == 3) ? '0 : pick_req(rmode);
            tx_lo_req = (rmode == 1 || rmode == 3) ? '0 : ((rmode == 2) ? 4'hF : pick_req(rmode));
            rx_lo_req = (rmode == 1 || rmode == 3) ? '0 : ((rmode == 2) ? 4'hF : pick_req(rmode));
            case (dmode)
                0: begin tx_done = |{tx_hi_gnt, tx_lo_gnt}; rx_done = |{rx_hi_gnt, rx_lo_gnt}; end
                1: begin
                    tx_done = |{tx_hi_gnt, tx_lo_gnt} && ($urandom % 4 == 0);
                    rx_done = |{rx_hi_gnt, rx_lo_gnt} && ($urandom % 4 == 0);
                end
                2: begin tx_done = ($urandom % 3 == 0); rx_done = ($urandom % 3 == 0); end
                default: begin tx_done = 1'b0; rx_done = 1'b0; end
            endcase
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        cfg_word = 32'd3 | (32'd5 << 8);
        run("R1 steady ratio", 80, 0, 0);
        lo_seen = 0;
        run("R1 slow share", 40, 0, 0);
        total++;
        if (lo_seen != 10) begin
            bad++;
            $display("FAIL R1 slow grants in 40 cycles actual=%0d expected=10", lo_seen);
        end
        cfg_word = 32'd0;
        run("R4 zero ratio", 40, 0, 0);
        cfg_word = 32'hFFFF_E0E0 | 32'd2 | (32'd6 << 8);
        run("R9 field placement", 60, 0, 0);
        cfg_word = 32'd3 | (32'd4 << 8);
        run("R2 fast only", 20, 1, 0);
        run("R2 idle gap", 5, 3, 2);
        run("R2 contest after gap", 20, 0, 0);
        run("R3 slow only", 10, 2, 0);
        run("R3 contest", 20, 0, 0);
        run("R10 lone fast", 30, 1, 1);
        run("R10 lone slow", 30, 2, 1);
        run("R7 held grant", 40, 0, 3);
        run("R7 stray done", 100, 4, 2);
        run("R8 rotation", 200, 4, 1);
        cfg_word = 32'd20 | (32'd20 << 8);
        run("R11 build count", 60, 1, 0);
        run("R11 mid packet", 5, 0, 3);
        cfg_word = 32'd3 | (32'd2 << 8);
        run("R11 new ratio", 40, 0, 0);
        run("R5 R6 random", 600, 5, 1);
        rst_n = 1'b0;
        run("R12 reset again", 4, 0, 0);
        rst_n = 1'b1;
        run("R12 after reset", 20, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule